// File: doc/BRIEF.md
# Interrupt Mask Router with Per-Type Priority Encoding

This block takes three 32-bit vectors of active interrupt sources: timer events, external hardware lines and software-triggered events. It routes them to a parameterized number of interrupt output lines. Every output line owns one 32-bit mask for each source type. The line is raised whenever at least one source is both active and enabled by the matching mask. The block does not produce the source vectors, and the bus protocol in front of the register port is outside its scope.

Software reaches the masks through a simple 32-bit word port. The port has separate read and write strobes and takes a 12-bit byte offset, decoded as a 5-bit function code in bits 11:7, a 5-bit output index in bits 6:2 and two bits 1:0 that must be zero. A mask can be loaded whole, have bits OR-ed in, or have bits cleared with an AND-NOT. The set and clear aliases let one handler enable or disable a source for one output without a read-modify-write race. Reads return a mask, the masked active vector of one type, or a packed priority word. For each type, the priority word gives a valid flag and the index of the winning source, where the lowest index wins. No priority is imposed between the three types.

Top module: `irq_mask_router`

## Requirements
- R1: A synchronous active-low reset clears every mask. After reset every irq bit is 0, and `rdata` is 0.
- R2: The function code is offset bits 11:7 and the output index is bits 6:2. An access whose bits 1:0 are not 00 is ignored: a write changes nothing and a read returns 0.
- R3: A write with code 00100 (timer), 01000 (hardware) or 01100 (software) loads `wdata` into that type's mask of the indexed output. A read of the same code returns that mask.
- R4: A write with code 00101, 01001 or 01101 ORs `wdata` into the matching mask. Other bits and other outputs are unchanged.
- R5: A write with code 00110, 01010 or 01110 clears the mask bits that are set in `wdata` (AND with the complement).
- R6: A read of code 00110, 01010 or 01110 returns the matching source vector AND-ed with that output's mask for the type.
- R7: A read of code 01111 returns the priority word. Bit 0, bit 1 and bit 2 flag any active unmasked timer, hardware and software source respectively. The winner indexes sit in bits 12:8 (timer), 20:16 (hardware) and 28:24 (software). Every other bit is 0.
- R8: Within a type, the winner is the lowest-numbered source that is active and unmasked. A type with no such source reports valid 0 and index 0.
- R9: irq[o] is 1 exactly when (timer & timer mask) | (hw & hw mask) | (sw & sw mask) is nonzero for output o. The masks of different outputs and types are independent.
- R10: The following reads return 0: the set codes 00101, 01001 and 01101; the reserved codes 00111, 01011 and 1xxxx; and any index at or above the output count. The following writes change no mask: to code 01111, to reserved codes, and to an index at or above the output count.
- R11: Read data appears on `rdata` in the clock cycle after the `rd_en` cycle and is 0 in every other cycle. A read issued in the same cycle as a write to the same mask returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one word |
| rd_en | input | 1 | Read strobe for one word |
| addr | input | 12 | Byte offset: function code, output index, two zero bits |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, 0 when no read was issued |
| tmr_src | input | 32 | Active timer sources |
| hw_src | input | 32 | Active hardware-line sources |
| sw_src | input | 32 | Active software-triggered sources |
| irq | output | N_OUT | Output interrupt lines |

## Verification
The assertions check several properties on every cycle:
- irq is low while no source is active.
- irq stays steady when neither sources nor masks could have changed.
- rdata is 0 outside the cycle after a read.
- Illegal reads return 0.
- An active read shows no bit absent from its source vector.
- A flagged priority winner really is an active source, and the reserved priority bits stay clear.

The exact mask arithmetic of load, set and clear cannot be seen from the ports alone. Neither can the lowest-index choice among several candidates, the independence of outputs, or the read-before-write ordering. The bench's sweeps show these, comparing read-back values and irq against masks it tracks itself.

// File: rtl/irqr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the interrupt mask router.
// Assumes 32 sources per type and a 12-bit word-aligned register offset.
package irqr_pkg;
    localparam int SRC_W  = 32;
    localparam int IDX_W  = $clog2(SRC_W);
    localparam int FUNC_W = 5;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int KINDS  = 3;

    // Source type; the numbering is also the mask slot order.
    typedef enum logic [1:0] {
        SRC_TMR  = 2'd0,
        SRC_HW   = 2'd1,
        SRC_SW   = 2'd2,
        SRC_NONE = 2'd3
    } src_kind_e;

    // Write action applied to one mask.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } mask_op_e;

    // What a read returns.
    typedef enum logic [1:0] {
        RD_ZERO   = 2'd0,
        RD_MASK   = 2'd1,
        RD_ACTIVE = 2'd2,
        RD_PRIO   = 2'd3
    } rd_sel_e;

    // Decoded register offset.
    typedef struct packed {
        src_kind_e        kind;
        mask_op_e         wop;
        rd_sel_e          rsel;
        logic [IDX_W-1:0] idx;
    } dec_t;
endpackage

// File: rtl/irqr_decode.sv
`timescale 1ns/1ps
// Offset decoder: turns a 12-bit byte offset into a source type, a write
// action, a read selection and an output index.
// Assumes: bits 11:7 function, 6:2 index, 1:0 zero. An illegal offset
// yields OP_NONE and RD_ZERO so it has no effect and reads zero.
module irqr_decode
    import irqr_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [FUNC_W-1:0] func;
    logic              idx_ok;

    assign func   = addr[ADDR_W-1 -: FUNC_W];
    assign idx_ok = (addr[1:0] == 2'b00) && (int'(addr[6:2]) < N_OUT);

    // Map the function code onto type, action and read selection.
    always_comb begin
        dec.kind = SRC_NONE;
        dec.wop  = OP_NONE;
        dec.rsel = RD_ZERO;
        dec.idx  = addr[6:2];
        if (!func[4]) begin
            unique case (func[3:2])
                2'b01:   dec.kind = SRC_TMR;
                2'b10:   dec.kind = SRC_HW;
                2'b11:   dec.kind = SRC_SW;
                default: dec.kind = SRC_NONE;
            endcase
            if (dec.kind != SRC_NONE) begin
                unique case (func[1:0])
                    2'b00: begin
                        dec.wop  = OP_LOAD;
                        dec.rsel = RD_MASK;
                    end
                    2'b01: dec.wop = OP_SET;
                    2'b10: begin
                        dec.wop  = OP_CLEAR;
                        dec.rsel = RD_ACTIVE;
                    end
                    default: begin
                        if (dec.kind == SRC_SW) dec.rsel = RD_PRIO;
                    end
                endcase
            end
        end
        if (!idx_ok) begin
            dec.wop  = OP_NONE;
            dec.rsel = RD_ZERO;
        end
    end
endmodule

// File: rtl/irqr_mask_reg.sv
`timescale 1ns/1ps
// One mask register with load, OR-set and AND-NOT-clear actions.
// Assumes the caller already gated the action to this mask.
module irqr_mask_reg
    import irqr_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mask_op_e     op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    // Apply the requested action; reset clears the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  mask <= wdata;
                OP_SET:   mask <= mask | wdata;
                OP_CLEAR: mask <= mask & ~wdata;
                default:  mask <= mask;
            endcase
        end
    end
endmodule

// File: rtl/irqr_lowest_first.sv
`timescale 1ns/1ps
// Lowest-index-first picker: reports whether any bit is set and the index
// of the lowest set bit, or index 0 when none is set.
// Assumes W is a power of two or at least that $clog2(W) bits hold W-1.
module irqr_lowest_first #(
    parameter int W  = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last and wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_mask_router.sv
`timescale 1ns/1ps
// Interrupt mask router: N_OUT output lines, each with a timer, hardware
// and software mask; per-type lowest-index winner for a priority word;
// registered read data, zero outside a read.
// Assumes full-word accesses, one per strobe; a read and a write in the
// same cycle are allowed and the read sees the pre-write state.
module irq_mask_router
    import irqr_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [SRC_W-1:0]  tmr_src,
    input  logic [SRC_W-1:0]  hw_src,
    input  logic [SRC_W-1:0]  sw_src,
    output logic [N_OUT-1:0]  irq
);
    localparam int PAD_W = 8 - IDX_W;

    dec_t              dec;
    logic [SRC_W-1:0]  src_w  [KINDS];
    logic [SRC_W-1:0]  mask_w [N_OUT][KINDS];
    logic [SRC_W-1:0]  act_w  [N_OUT][KINDS];
    logic              any_w  [N_OUT][KINDS];
    logic [IDX_W-1:0]  win_w  [N_OUT][KINDS];
    logic [DATA_W-1:0] prio_w [N_OUT];
    logic [DATA_W-1:0] rd_value;

    assign src_w[0] = tmr_src;
    assign src_w[1] = hw_src;
    assign src_w[2] = sw_src;

    irqr_decode #(.N_OUT(N_OUT)) u_decode (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        for (genvar k = 0; k < KINDS; k++) begin : g_kind
            mask_op_e op;

            // Gate the decoded action to this output and type.
            assign op = (wr_en && dec.idx == IDX_W'(o) && dec.kind == src_kind_e'(k))
                        ? dec.wop : OP_NONE;

            irqr_mask_reg #(.W(SRC_W)) u_mask (
                .clk   (clk),
                .rst_n (rst_n),
                .op    (op),
                .wdata (wdata),
                .mask  (mask_w[o][k])
            );

            assign act_w[o][k] = src_w[k] & mask_w[o][k];

            irqr_lowest_first #(.W(SRC_W)) u_pick (
                .vec   (act_w[o][k]),
                .found (any_w[o][k]),
                .idx   (win_w[o][k])
            );
        end

        // Output line: any enabled source of any type.
        assign irq[o] = any_w[o][0] | any_w[o][1] | any_w[o][2];

        // Packed priority word: flags in 2:0, winners at byte lanes 1..3.
        assign prio_w[o] = {{PAD_W{1'b0}}, win_w[o][2],
                            {PAD_W{1'b0}}, win_w[o][1],
                            {PAD_W{1'b0}}, win_w[o][0],
                            5'b0, any_w[o][2], any_w[o][1], any_w[o][0]};
    end

    // Select the word a read returns.
    always_comb begin
        rd_value = '0;
        for (int o = 0; o < N_OUT; o++) begin
            if (dec.idx == IDX_W'(o)) begin
                for (int k = 0; k < KINDS; k++) begin
                    if (dec.kind == src_kind_e'(k)) begin
                        if (dec.rsel == RD_MASK)   rd_value = mask_w[o][k];
                        if (dec.rsel == RD_ACTIVE) rd_value = act_w[o][k];
                    end
                end
                if (dec.rsel == RD_PRIO) rd_value = prio_w[o];
            end
        end
    end

    // Register the read word for one cycle; zero when no read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_en ? rd_value : '0;
        end
    end
endmodule

// File: rtl/irqr_checker.sv
`timescale 1ns/1ps
// Port-level checker for irq_mask_router, attached by bind.
// Assumes the same N_OUT as the bound instance.
module irqr_checker
    import irqr_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [SRC_W-1:0]  tmr_src,
    input logic [SRC_W-1:0]  hw_src,
    input logic [SRC_W-1:0]  sw_src,
    input logic [N_OUT-1:0]  irq
);
    logic legal;
    logic rd_bad;
    logic rd_prio;
    logic rd_tmr_act;

    assign legal      = (addr[1:0] == 2'b00) && (int'(addr[6:2]) < N_OUT);
    assign rd_bad     = rd_en && (!legal || addr[11]);
    assign rd_prio    = rd_en && legal && (addr[11:7] == 5'b01111);
    assign rd_tmr_act = rd_en && legal && (addr[11:7] == 5'b00110);

    AST_RESET_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0));                                   // R1
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rdata == '0));                                // R11
    AST_ILLEGAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_bad) |-> (rdata == '0));                                // R10
    AST_NO_SOURCE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_src == '0 && hw_src == '0 && sw_src == '0) |-> (irq == '0)); // R9
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $stable(tmr_src) && $stable(hw_src)
         && $stable(sw_src)) |-> $stable(irq));                          // R9
    AST_ACTIVE_WITHIN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_tmr_act) |-> ((rdata & ~$past(tmr_src)) == '0));        // R6
    AST_PRIO_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_prio) |-> (rdata[31:29] == 3'b0 && rdata[23:21] == 3'b0
                            && rdata[15:13] == 3'b0 && rdata[7:3] == 5'b0)); // R7
    AST_PRIO_WINNER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_prio) && rdata[0]) |-> ((($past(tmr_src) >> rdata[12:8]) & 32'd1) == 32'd1)); // R8
    AST_PRIO_FLAG_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_prio) |-> ((!rdata[1] || $past(hw_src) != '0)
                            && (!rdata[2] || $past(sw_src) != '0)));     // R7
endmodule

bind irq_mask_router irqr_checker #(.N_OUT(N_OUT)) u_irqr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .tmr_src (tmr_src),
    .hw_src  (hw_src),
    .sw_src  (sw_src),
    .irq     (irq)
);

// File: tb/tb_irq_mask_router.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps a 3-output configuration with a mask model.
module tb_irq_mask_router;
    localparam int NO = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] tmr_src = '0;
    logic [31:0] hw_src = '0;
    logic [31:0] sw_src = '0;
    logic [NO-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] m [NO][3];

    always #2.5 clk = ~clk;

    irq_mask_router #(.N_OUT(NO)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tmr_src(tmr_src), .hw_src(hw_src),
        .sw_src(sw_src), .irq(irq)
    );

    function automatic logic [11:0] ad(input logic [4:0] f, input int i);
        return {f, 5'(i), 2'b00};
    endfunction

    function automatic logic [4:0] code(input int k, input int sub);
        return 5'((k + 1) * 4 + sub);
    endfunction

    function automatic logic [31:0] pat(input int o, input int k, input int n);
        return (32'h9E37_79B9 * 32'(o * 3 + k + 1 + n * 7)) ^ (32'h1 << ((o * 5 + k * 11 + n) % 32));
    endfunction

    function automatic logic [31:0] exp_prio(input logic [31:0] t, input logic [31:0] h, input logic [31:0] s);
        logic [31:0] r;
        logic [31:0] v [3];
        r = '0;
        v[0] = t; v[1] = h; v[2] = s;
        for (int k = 0; k < 3; k++)
            for (int i = 31; i >= 0; i--)
                if (v[k][i]) begin
                    r[k] = 1'b1;
                    r[8 * (k + 1) +: 5] = 5'(i);
                end
        return r;
    endfunction

    function automatic logic [NO-1:0] exp_irq();
        logic [NO-1:0] e;
        for (int o = 0; o < NO; o++)
            e[o] = |((tmr_src & m[o][0]) | (hw_src & m[o][1]) | (sw_src & m[o][2]));
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(posedge clk);
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_all_masks(input string req);
        logic [31:0] d;
        for (int o = 0; o < NO; o++)
            for (int k = 0; k < 3; k++) begin
                bus_rd(ad(code(k, 0), o), d);
                chk(req, d, m[o][k]);
            end
    endtask

    task automatic set_src(input logic [31:0] t, input logic [31:0] h, input logic [31:0] s);
        @(negedge clk);
        tmr_src = t; hw_src = h; sw_src = s;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int o = 0; o < NO; o++) for (int k = 0; k < 3; k++) m[o][k] = '0;

        // R1: reset with sources active
        tmr_src = '1; hw_src = '1; sw_src = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 irq after reset", 32'(irq), 32'(0));
        chk("R1 rdata after reset", rdata, 32'h0);
        bus_rd(ad(5'b01111, 0), d);
        chk("R1 prio after reset", d, 32'h0);
        check_all_masks("R1 mask after reset");
        set_src('0, '0, '0);

        // R3: load and read back every mask (distinct per index: R2)
        for (int o = 0; o < NO; o++)
            for (int k = 0; k < 3; k++) begin
                m[o][k] = pat(o, k, 0);
                bus_wr(ad(code(k, 0), o), m[o][k]);
            end
        check_all_masks("R3 load readback");

        // R4: OR-set
        for (int o = 0; o < NO; o++)
            for (int k = 0; k < 3; k++) begin
                m[o][k] = m[o][k] | pat(o, k, 1);
                bus_wr(ad(code(k, 1), o), pat(o, k, 1));
            end
        check_all_masks("R4 set readback");

        // R5: AND-NOT clear
        for (int o = 0; o < NO; o++)
            for (int k = 0; k < 3; k++) begin
                m[o][k] = m[o][k] & ~pat(o, k, 2);
                bus_wr(ad(code(k, 2), o), pat(o, k, 2));
            end
        check_all_masks("R5 clear readback");

        // R6 and R9: active reads and irq under several source patterns
        for (int n = 0; n < 6; n++) begin
            set_src(pat(n, 0, 3) & (32'hFFFF_FFFF >> (n * 5)),
                    pat(n, 1, 4) & (32'hFFFF_FFFF << (n * 4)),
                    (n == 5) ? 32'h0 : pat(n, 2, 5));
            chk("R9 irq", 32'(irq), 32'(exp_irq()));
            for (int o = 0; o < NO; o++) begin
                bus_rd(ad(code(0, 2), o), d); chk("R6 timer active", d, tmr_src & m[o][0]);
                bus_rd(ad(code(1, 2), o), d); chk("R6 hw active", d, hw_src & m[o][1]);
                bus_rd(ad(code(2, 2), o), d); chk("R6 sw active", d, sw_src & m[o][2]);
            end
        end

        // R9: single-source walk per output and type
        for (int o = 0; o < NO; o++)
            for (int k = 0; k < 3; k++) begin
                m[o][k] = 32'h1 << (o * 3 + k);
                bus_wr(ad(code(k, 0), o), m[o][k]);
            end
        for (int b = 0; b < 10; b++) begin
            set_src(32'h1 << b, 32'h1 << b, 32'h1 << b);
            chk("R9 walk irq", 32'(irq), 32'(exp_irq()));
        end
        set_src('0, '0, '0);
        chk("R9 no source irq", 32'(irq), 32'(0));

        // R10: illegal reads return zero
        set_src('1, '1, '1);
        for (int k = 0; k < 3; k++) begin
            bus_rd(ad(code(k, 1), 0), d); chk("R10 read of set code", d, 32'h0);
        end
        bus_rd(ad(5'b00111, 0), d); chk("R10 read reserved 00111", d, 32'h0);
        bus_rd(ad(5'b01011, 0), d); chk("R10 read reserved 01011", d, 32'h0);
        bus_rd(ad(5'b10000, 0), d); chk("R10 read reserved 10000", d, 32'h0);
        bus_rd(ad(5'b11111, 1), d); chk("R10 read reserved 11111", d, 32'h0);
        bus_rd(ad(5'b00100, NO), d); chk("R10 read index out of range", d, 32'h0);
        bus_rd(ad(5'b01111, 31), d); chk("R10 prio index out of range", d, 32'h0);

        // R10: ignored writes
        bus_wr(ad(5'b00100, NO), 32'hFFFF_FFFF);
        bus_wr(ad(5'b01000, 31), 32'hFFFF_FFFF);
        bus_wr(ad(5'b01111, 0), 32'hFFFF_FFFF);
        bus_wr(ad(5'b00111, 1), 32'hFFFF_FFFF);
        bus_wr(ad(5'b10100, 2), 32'hFFFF_FFFF);
        check_all_masks("R10 masks after ignored writes");
        chk("R10 irq after ignored writes", 32'(irq), 32'(exp_irq()));

        // R2: misaligned offsets
        bus_wr(ad(5'b00100, 0) | 12'h1, 32'hFFFF_FFFF);
        bus_wr(ad(5'b01101, 1) | 12'h3, 32'hFFFF_FFFF);
        check_all_masks("R2 masks after misaligned writes");
        bus_rd(ad(5'b00100, 0) | 12'h2, d); chk("R2 misaligned read", d, 32'h0);

        // R7 and R8: priority sweep, full masks on output 0, partial on 1
        m[0][0] = '1; m[0][1] = '1; m[0][2] = '1;
        m[1][0] = 32'hFFFF_0000; m[1][1] = 32'h5555_5555; m[1][2] = 32'h0F0F_F0F0;
        for (int o = 0; o < 2; o++)
            for (int k = 0; k < 3; k++) bus_wr(ad(code(k, 0), o), m[o][k]);
        for (int p = 0; p < 32; p++) begin
            set_src((32'h1 << p) | 32'h8000_0000,
                    32'hFFFF_FFFF << p,
                    (p % 2 == 1) ? 32'h0 : (32'h1 << (31 - p)));
            for (int o = 0; o < NO; o++) begin
                bus_rd(ad(5'b01111, o), d);
                chk("R8 prio winner", d, exp_prio(tmr_src & m[o][0], hw_src & m[o][1], sw_src & m[o][2]));
            end
        end
        set_src('0, '0, '0);
        bus_rd(ad(5'b01111, 0), d); chk("R8 no active source", d, 32'h0);
        set_src(32'h0000_0100, 32'h0002_0000, 32'h4000_0001);
        bus_rd(ad(5'b01111, 0), d); chk("R7 word layout", d, 32'h0011_0807);

        // R11: read and write in the same cycle see the old mask
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = ad(code(1, 0), 2); wdata = 32'hCAFE_0001;
        @(posedge clk);
        #1 chk("R11 read before write", rdata, m[2][1]);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        m[2][1] = 32'hCAFE_0001;
        @(posedge clk);
        #1 chk("R11 rdata idle zero", rdata, 32'h0);
        bus_rd(ad(code(1, 0), 2), d); chk("R11 new value", d, 32'hCAFE_0001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule